// File: doc/BRIEF.md
# Sticky Active-Low Overflow Interrupt Register

This block collects overflow events from four channels into a sticky, active-low status register. A status bit that has dropped stays low until software reads the status register, and that read returns the bits to one. A mask register picks which channels may pull the shared interrupt line. The interrupt is presented as an active-low level with a separate output-enable, so that a pad outside the block can model an open-drain driver.

Software reaches both registers through a small address-selected port. Read data is combinational from the selected register, so it is valid in the same cycle as the read strobe. A status read takes effect at the next clock edge. A masked channel still records its overflow, so software can poll for it.

Top module: `ovf_irq_regs`

## Requirements
- R1: After reset the status register reads 0xFF, the mask register reads 0xFF, irq_n_o is 1 and irq_oe_o is 0.
- R2: When `ovf_evt_i[k]` is high at a clock edge, status bit k reads 0 from the next cycle on. Bit 0 belongs to channel 1 and bit 3 to channel 4.
- R3: A low status bit stays low across cycles without a status read. A status read (rd_en_i=1, addr_i=0) returns the current value, and after that edge every status bit without a new event reads 1.
- R4: If an event on channel k arrives in the same cycle as a status read, the read returns the old value and bit k is 0 after the edge.
- R5: Bits 7:4 read as 1 in both registers, and writes to these bits have no effect.
- R6: A write (wr_en_i=1, addr_i=1) loads wr_data_i[3:0] into the mask, which reads back from the next cycle. Mask bit 1 enables a channel and mask bit 0 blocks it.
- R7: irq_n_o is 0 and irq_oe_o is 1 exactly when some status bit is 0 and its mask bit is 1. In every other case irq_n_o is 1 and irq_oe_o is 0.
- R8: A channel whose mask bit is 0 still drives its status bit low on an event, without driving the interrupt.
- R9: The status register is read-only. Writes to address 0, and writes to unmapped addresses 2 and 3, change no state. Reads of unmapped addresses return 0xFF.
- R10: A read of the mask register leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovf_evt_i | input | 4 | Overflow event strobes; bit 0 is channel 1 |
| rd_en_i | input | 1 | Read strobe; a read of address 0 clears the status bits |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 mask |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Selected register, combinational |
| irq_n_o | output | 1 | Interrupt level, active low |
| irq_oe_o | output | 1 | Interrupt output-enable; high while the interrupt is pulled low |

## Verification
The hardest case to reach is an overflow event that lands in the very cycle a status read clears the register. If the design handles it wrong, the event is lost without any sign. The bench creates this case with directed steps, and also through random stimulus that drives the read strobe and the event strobes independently in the same cycle. In both cases the bench compares the value the read returns and the bits that stay low against its model. Masked channels are made to overflow while the interrupt is watched, which shows that status latching and interrupt gating are independent.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
  localparam int unsigned NUM_CH      = 4;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ADDR_W      = 2;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_MASK   = 1;
endpackage

// File: rtl/ovf_status_bank.sv
module ovf_status_bank #(
  parameter int unsigned NUM_CH = ovf_irq_pkg::NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] st_o
);
  logic [NUM_CH-1:0] st_q, st_d;

  // active low; clear first, then a new event wins
  for (genvar k = 0; k < NUM_CH; k++) begin : g_bit
    always_comb begin
      st_d[k] = clr_i ? 1'b1 : st_q[k];
      if (evt_i[k]) st_d[k] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '1;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/ovf_mask_reg.sv
module ovf_mask_reg #(
  parameter int unsigned NUM_CH = ovf_irq_pkg::NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NUM_CH-1:0] wd_i,
  output logic [NUM_CH-1:0] mask_o
);
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wd_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ovf_irq_drive.sv
module ovf_irq_drive #(
  parameter int unsigned NUM_CH = ovf_irq_pkg::NUM_CH
) (
  input  logic [NUM_CH-1:0] st_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic [NUM_CH-1:0] req;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_req
    assign req[k] = ~st_i[k] & mask_i[k];
  end

  assign irq_oe_o = |req;
  assign irq_n_o  = ~(|req);
endmodule

// File: rtl/ovf_irq_regs.sv
module ovf_irq_regs #(
  parameter int unsigned NUM_CH      = ovf_irq_pkg::NUM_CH,
  parameter int unsigned DATA_W      = ovf_irq_pkg::DATA_W,
  parameter int unsigned ADDR_W      = ovf_irq_pkg::ADDR_W,
  parameter int unsigned ADDR_STATUS = ovf_irq_pkg::ADDR_STATUS,
  parameter int unsigned ADDR_MASK   = ovf_irq_pkg::ADDR_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ovf_evt_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_CH;
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_MK = ADDR_W'(ADDR_MASK);

  logic [NUM_CH-1:0] st_q, mask_q;
  logic st_clr, mask_we;

  assign st_clr  = rd_en_i && (addr_i == A_ST);
  assign mask_we = wr_en_i && (addr_i == A_MK);

  ovf_status_bank #(.NUM_CH(NUM_CH)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (ovf_evt_i),
    .clr_i (st_clr),
    .st_o  (st_q)
  );

  ovf_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (mask_we),
    .wd_i  (wr_data_i[NUM_CH-1:0]),
    .mask_o(mask_q)
  );

  ovf_irq_drive #(.NUM_CH(NUM_CH)) u_irq (
    .st_i    (st_q),
    .mask_i  (mask_q),
    .irq_n_o (irq_n_o),
    .irq_oe_o(irq_oe_o)
  );

  // reserved and unmapped bits read as ones
  always_comb begin
    rd_data_o = '1;
    if (addr_i == A_ST)      rd_data_o = {{PAD_W{1'b1}}, st_q};
    else if (addr_i == A_MK) rd_data_o = {{PAD_W{1'b1}}, mask_q};
  end
endmodule

// File: rtl/ovf_irq_chk.sv
module ovf_irq_chk #(
  parameter int unsigned NUM_CH = ovf_irq_pkg::NUM_CH,
  parameter int unsigned DATA_W = ovf_irq_pkg::DATA_W,
  parameter int unsigned ADDR_W = ovf_irq_pkg::ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ovf_evt_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_n_o,
  input logic              irq_oe_o,
  input logic [NUM_CH-1:0] st_q,
  input logic [NUM_CH-1:0] mask_q
);
  logic stat_rd, mask_wr;
  assign stat_rd = rd_en_i && (addr_i == ADDR_W'(ovf_irq_pkg::ADDR_STATUS));
  assign mask_wr = wr_en_i && (addr_i == ADDR_W'(ovf_irq_pkg::ADDR_MASK));

  // R2
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_evt_i) |=> ((st_q & $past(ovf_evt_i)) == '0));

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd |=> ((~$past(st_q) & st_q) == '0));

  // R4
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> (st_q == ~$past(ovf_evt_i)));

  // R5
  rsvd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &rd_data_o[DATA_W-1:NUM_CH]);

  // R6
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> (mask_q == $past(wr_data_i[NUM_CH-1:0])));

  // R7
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~st_q & mask_q)) |-> (!irq_n_o && irq_oe_o));

  // R7
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~st_q & mask_q) == '0) |-> (irq_n_o && !irq_oe_o));
endmodule

bind ovf_irq_regs ovf_irq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ovf_evt_i(ovf_evt_i),
  .rd_en_i  (rd_en_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .irq_n_o  (irq_n_o),
  .irq_oe_o (irq_oe_o),
  .st_q     (st_q),
  .mask_q   (mask_q)
);

// File: tb/sim_ovf_irq_regs.sv
`timescale 1ns/1ps
module sim_ovf_irq_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       irq_n, irq_oe;

  int unsigned n_chk = 0, n_fail = 0;
  logic [3:0] m_st = 4'hF, m_mask = 4'hF;
  bit done = 0;

  always #2.5 clk = ~clk;

  ovf_irq_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .ovf_evt_i(evt), .rd_en_i(rd), .wr_en_i(wr),
    .addr_i(addr), .wr_data_i(wd), .rd_data_o(rdata), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    if (a == 2'd0) return {4'hF, m_st};
    if (a == 2'd1) return {4'hF, m_mask};
    return 8'hFF;
  endfunction

  function automatic logic exp_irq_n();
    return ((~m_st & m_mask) == 4'h0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check outputs, then update model at posedge
  task automatic step(input logic [3:0] e, input logic r, input logic w,
                      input logic [1:0] a, input logic [7:0] d,
                      input string rtag, input string itag);
    @(negedge clk);
    evt = e; rd = r; wr = w; addr = a; wd = d;
    #1;
    if (rtag != "") chk(rdata == exp_read(a), rtag, {8'h0, rdata}, {8'h0, exp_read(a)});
    if (itag != "") chk((irq_n == exp_irq_n()) && (irq_oe == !exp_irq_n()), itag,
                        {14'h0, irq_n, irq_oe}, {14'h0, exp_irq_n(), !exp_irq_n()});
    @(posedge clk);
    if (w && a == 2'd1) m_mask = d[3:0];
    if (r && a == 2'd0) m_st = ~e;
    else                m_st = m_st & ~e;
  endtask

  task automatic idle(input string rtag, input logic [1:0] a, input string itag);
    step(4'h0, 1'b0, 1'b0, a, 8'h00, rtag, itag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state while held in reset
    #1;
    chk(rdata == 8'hFF, "R1 status", {8'h0, rdata}, 16'h00FF);
    chk(irq_n && !irq_oe, "R1 irq", {14'h0, irq_n, irq_oe}, 16'h0002);
    @(negedge clk); rst_n = 1'b1;
    idle("R1", 2'd1, "R1");
    idle("R1", 2'd0, "R1");

    // R2: channel 3 (bit 2)
    step(4'h4, 1'b0, 1'b0, 2'd0, 8'h00, "", "");
    idle("R2", 2'd0, "R7");
    // R3: sticky across idle cycles, then read clears
    idle("R3", 2'd0, "R3");
    idle("R3", 2'd0, "R3");
    step(4'h0, 1'b1, 1'b0, 2'd0, 8'h00, "R3", "R7");
    idle("R3", 2'd0, "R3");
    // R4: event on ch2 coincident with read while ch1 pending
    step(4'h1, 1'b0, 1'b0, 2'd0, 8'h00, "", "");
    step(4'h2, 1'b1, 1'b0, 2'd0, 8'h00, "R4", "");
    idle("R4", 2'd0, "R4");
    // R10: mask read leaves status
    step(4'h0, 1'b1, 1'b0, 2'd1, 8'h00, "R10", "");
    idle("R10", 2'd0, "R10");
    step(4'h0, 1'b1, 1'b0, 2'd0, 8'h00, "R3", "");
    // R5/R6: mask writes with reserved bits
    step(4'h0, 1'b0, 1'b1, 2'd1, 8'h05, "", "");
    idle("R6", 2'd1, "");
    step(4'h0, 1'b0, 1'b1, 2'd1, 8'h00, "", "");
    idle("R5", 2'd1, "R7");
    // R8: masked channels latch without interrupt
    step(4'hF, 1'b0, 1'b0, 2'd0, 8'h00, "", "");
    idle("R8", 2'd0, "R8");
    // R7: unmask one channel asserts irq
    step(4'h0, 1'b0, 1'b1, 2'd1, 8'h08, "", "");
    idle("R7", 2'd0, "R7");
    // R9: writes to status and unmapped addresses ignored
    step(4'h0, 1'b0, 1'b1, 2'd0, 8'hFF, "", "");
    step(4'h0, 1'b0, 1'b1, 2'd2, 8'h00, "R9", "");
    step(4'h0, 1'b0, 1'b1, 2'd3, 8'h00, "R9", "");
    idle("R9", 2'd0, "R9");
    idle("R9", 2'd1, "");
    step(4'h0, 1'b1, 1'b0, 2'd0, 8'h00, "R3", "");
    idle("R7", 2'd0, "R7");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0] e;
      logic r, w;
      logic [1:0] a;
      e = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      r = ($urandom % 3) == 0;
      w = ($urandom % 5) == 0;
      a = 2'($urandom);
      step(e, r, w, a, 8'($urandom), (r && a == 2'd0) ? "R4" : "R6", "R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule